// File: doc/BRIEF.md
# LIN Transmitter Fault Supervisor

This block watches the transmit-data line that a microcontroller drives towards a LIN transceiver, together with the bus level read back from that transceiver. It recognises three fault conditions and acts on each one in its own way. A transmit line held dominant for too long, or a bus that stays recessive while the block is transmitting, switches the driver enable off. A bus held dominant beyond a longer limit switches the bus termination off instead. All inputs and timers run in the system clock domain. The read-back bus line is first brought through a short synchronizer chain.

A disabled driver returns in one of two ways. It can return by itself once conditions show the fault has gone: for a stuck transmit line this needs a recessive transmit line plus a falling edge on the bus; for a recessive clamp it needs a falling edge on the bus. It can also return when software writes the recovery bit high and then low again. Each fault has a live flag, which software can read. Any change of a live flag, in either direction, latches a sticky status bit when the matching enable is set, and the interrupt output follows those status bits. Two further control bits, slope select and drive boost, go straight to outputs for the analog front end.

Top module: `lin_txfault_sup`

## Requirements
- R1: After reset the driver enable and termination enable are 1, the interrupt, slope-select and drive-boost outputs are 0, and the live-flag and status registers read 0.
- R2: When the transmit input (0 = dominant) stays at 0 for more than TXD_TIMEOUT clock cycles, the driver enable goes to 0 and live flag bit 0 reads 1. A shorter dominant stretch leaves the driver enabled.
- R3: After a transmit-stuck fault, the driver re-enables automatically only when the transmit input is 1 and the synchronized bus shows a 1-to-0 edge. A bus edge while the transmit input is still 0 does not re-enable it, and neither does the transmit input returning to 1 without a bus edge.
- R4: Writing register 0 bit 0 to 1 and then to 0 clears the transmit-stuck and recessive-clamp faults and re-enables the driver. Writing the 1 alone leaves the driver disabled.
- R5: When the driver is enabled, the transmit input is 0 and the synchronized bus reads 1 (recessive) for more than CLAMP_FILT cycles, the driver enable goes to 0 and live flag bit 2 reads 1.
- R6: After a recessive-clamp fault, the driver re-enables automatically on the next 1-to-0 edge of the synchronized bus.
- R7: When the synchronized bus stays 0 for more than BUS_TIMEOUT cycles (BUS_TIMEOUT > TXD_TIMEOUT), the termination enable goes to 0 and live flag bit 1 reads 1. The driver enable is not affected. Both return to their idle values once the bus reads 1 again.
- R8: Any change of a live flag bit latches the matching bit of the status register (address 2) when the enable register (address 1) has that bit set. A status bit stays set until a 1 is written to it. The interrupt output is 1 exactly while some status bit is set.
- R9: A live-flag change whose enable bit is 0 leaves its status bit at 0 and the interrupt at 0.
- R10: Register 0 bit 1 drives the slope-select output and bit 2 drives the drive-boost output. Register 0 reads back what was written in bits 2:0.
- R11: The register map is: address 0 control, address 1 interrupt enable, address 2 status (write 1 to clear), address 3 live flags (read only). Fault bit order is 0 transmit stuck, 1 bus dominant, 2 recessive clamp. Read data is registered and appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_in | input | 1 | Transmit data from the controller, 0 = dominant |
| bus_rx | input | 1 | Bus level read back from the transceiver, asynchronous, 0 = dominant |
| tx_en | output | 1 | Driver enable, 1 = driver may transmit |
| term_en | output | 1 | Bus termination enable |
| slope_low | output | 1 | Low-slope mode select for the driver |
| drive_boost | output | 1 | Increased drive strength select |
| irq | output | 1 | Interrupt request, high while any status bit is set |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for the address of the previous cycle |

## Verification
The bench models the bus as the wired combination of the driver, a short to ground, a short to the supply and another node pulling dominant. It drives the transmit input just below and just above each timeout. An off-by-a-lot timer would disable the driver on a legal long frame or never disable it at all. It tries the recovery paths in the wrong order: a bus edge while the transmit line is still dominant, a recessive transmit line with no bus edge, and a write of the recovery bit without the following clear. A design that recovered on a single condition would re-enable the driver in those windows. It also checks that a stuck-dominant bus moves only the termination, that a masked fault change never reaches the status or interrupt, and that write-one-to-clear drops the interrupt.

// File: rtl/lin_sup_pkg.sv
package lin_sup_pkg;

  localparam int NFLT    = 3;
  localparam int F_TXD   = 0;
  localparam int F_BUS   = 1;
  localparam int F_CLAMP = 2;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_IEN   = 2'd1;
  localparam logic [1:0] A_ISTAT = 2'd2;
  localparam logic [1:0] A_LIVE  = 2'd3;

  typedef struct packed {
    logic boost;
    logic slope_low;
    logic xctl;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/lin_bus_sync.sv
module lin_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_async,
  output logic bus_s,
  output logic bus_fall
);

  generate
    if (STAGES < 2) begin : g_bad
      $error("lin_bus_sync needs at least two stages");
    end
  endgenerate

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], bus_async};
      prev  <= chain[STAGES-1];
    end
  end

  assign bus_s    = chain[STAGES-1];
  assign bus_fall = prev & ~chain[STAGES-1];

  // R3: a falling edge is reported for one cycle only
  a_r3_fall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    bus_fall |=> !bus_fall);

endmodule

// File: rtl/lin_dom_timer.sv
module lin_dom_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic clr,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !active) begin
      cnt <= '0;
    end else if (cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = active && (cnt == LIM);

  // R2: the count never passes its limit
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  // R5: leaving the dominant condition restarts the count
  a_r5_idle_restarts: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0));

endmodule

// File: rtl/lin_fault_regs.sv
module lin_fault_regs
  import lin_sup_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NFLT-1:0]   live,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              man_clr,
  output logic              irq
);

  generate
    if (DATA_W < NFLT || DATA_W < CTRL_W) begin : g_bad
      $error("lin_fault_regs data width too small");
    end
  endgenerate

  ctrl_t             ctrl_q;
  logic [NFLT-1:0]   ien_q;
  logic [NFLT-1:0]   stat_q;
  logic [NFLT-1:0]   live_q;
  logic [NFLT-1:0]   stat_n;
  logic [NFLT-1:0]   w1c;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              man_q;
  logic              irq_q;
  logic              wr_ctrl, wr_ien, wr_stat;

  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_ien  = we && (addr == A_IEN);
  assign wr_stat = we && (addr == A_ISTAT);
  assign w1c     = wr_stat ? wdata[NFLT-1:0] : '0;

  // set beats clear when both land in the same cycle
  assign stat_n = (stat_q & ~w1c) | ((live ^ live_q) & ien_q);

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux[CTRL_W-1:0] = ctrl_q;
      A_IEN:   rd_mux[NFLT-1:0]   = ien_q;
      A_ISTAT: rd_mux[NFLT-1:0]   = stat_q;
      default: rd_mux[NFLT-1:0]   = live;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
      live_q  <= '0;
      rdata_q <= '0;
      man_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_ien)  ien_q  <= wdata[NFLT-1:0];
      man_q   <= wr_ctrl && ctrl_q.xctl && !wdata[0];
      live_q  <= live;
      stat_q  <= stat_n;
      irq_q   <= |stat_n;
      rdata_q <= rd_mux;
    end
  end

  assign rdata   = rdata_q;
  assign ctrl    = ctrl_q;
  assign man_clr = man_q;
  assign irq     = irq_q;

  generate
    for (genvar i = 0; i < NFLT; i++) begin : g_chk
      // R9: a status bit can only rise through an enabled source
      a_r9_stat_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[i]) |-> $past(ien_q[i]));
      // R8: a status bit only drops through a write of one
      a_r8_stat_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q[i]) |-> $past(w1c[i]));
    end
  endgenerate

endmodule

// File: rtl/lin_txfault_sup.sv
module lin_txfault_sup
  import lin_sup_pkg::*;
#(
  parameter int TXD_TIMEOUT = 2000,
  parameter int BUS_TIMEOUT = 6000,
  parameter int CLAMP_FILT  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txd_in,
  input  logic              bus_rx,
  output logic              tx_en,
  output logic              term_en,
  output logic              slope_low,
  output logic              drive_boost,
  output logic              irq,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  generate
    if (BUS_TIMEOUT <= TXD_TIMEOUT) begin : g_bad_order
      $error("bus dominant limit must exceed transmit dominant limit");
    end
    if (CLAMP_FILT <= SYNC_STAGES + 1) begin : g_bad_filt
      $error("clamp filter must cover the read-back latency");
    end
  endgenerate

  logic  bus_s, bus_fall;
  logic  man_clr;
  ctrl_t ctrl;
  logic  txd_exp, bus_exp, clamp_exp;
  logic  clamp_act;
  logic  f_txd, f_bus, f_clamp;
  logic  f_txd_n, f_bus_n, f_clamp_n;
  logic  tx_en_q, term_q;
  logic [NFLT-1:0] live;

  lin_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .bus_async(bus_rx),
    .bus_s    (bus_s),
    .bus_fall (bus_fall)
  );

  lin_dom_timer #(.LIMIT(TXD_TIMEOUT)) u_txd_tmr (
    .clk    (clk),
    .rst    (rst),
    .active (~txd_in),
    .clr    (man_clr),
    .expired(txd_exp)
  );

  lin_dom_timer #(.LIMIT(BUS_TIMEOUT)) u_bus_tmr (
    .clk    (clk),
    .rst    (rst),
    .active (~bus_s),
    .clr    (1'b0),
    .expired(bus_exp)
  );

  assign clamp_act = tx_en_q & ~txd_in & bus_s;

  lin_dom_timer #(.LIMIT(CLAMP_FILT)) u_clamp_tmr (
    .clk    (clk),
    .rst    (rst),
    .active (clamp_act),
    .clr    (man_clr),
    .expired(clamp_exp)
  );

  always_comb begin
    f_txd_n = f_txd;
    if (man_clr)                f_txd_n = 1'b0;
    else if (txd_exp)           f_txd_n = 1'b1;
    else if (txd_in && bus_fall) f_txd_n = 1'b0;

    f_clamp_n = f_clamp;
    if (man_clr)        f_clamp_n = 1'b0;
    else if (clamp_exp) f_clamp_n = 1'b1;
    else if (bus_fall)  f_clamp_n = 1'b0;

    f_bus_n = f_bus;
    if (bus_exp)    f_bus_n = 1'b1;
    else if (bus_s) f_bus_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_txd   <= 1'b0;
      f_bus   <= 1'b0;
      f_clamp <= 1'b0;
      tx_en_q <= 1'b1;
      term_q  <= 1'b1;
    end else begin
      f_txd   <= f_txd_n;
      f_bus   <= f_bus_n;
      f_clamp <= f_clamp_n;
      tx_en_q <= ~(f_txd_n | f_clamp_n);
      term_q  <= ~f_bus_n;
    end
  end

  always_comb begin
    live          = '0;
    live[F_TXD]   = f_txd;
    live[F_BUS]   = f_bus;
    live[F_CLAMP] = f_clamp;
  end

  lin_fault_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .live   (live),
    .rdata  (reg_rdata),
    .ctrl   (ctrl),
    .man_clr(man_clr),
    .irq    (irq)
  );

  assign tx_en       = tx_en_q;
  assign term_en     = term_q;
  assign slope_low   = ctrl.slope_low;
  assign drive_boost = ctrl.boost;

  // R2: the driver is only switched off while transmit data is dominant
  a_r2_off_needs_dom: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en_q) |-> !$past(txd_in));

  // R3: automatic release of a stuck transmit line needs recessive data and a bus edge
  a_r3_auto_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(f_txd) && !$past(man_clr)) |-> ($past(txd_in) && $past(bus_fall)));

  // R6: automatic release of a recessive clamp needs a bus edge
  a_r6_clamp_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(f_clamp) && !$past(man_clr)) |-> $past(bus_fall));

  // R7: termination is only dropped while the bus reads dominant
  a_r7_term_needs_dom: assert property (@(posedge clk) disable iff (rst)
    $fell(term_q) |-> !$past(bus_s));

endmodule

// File: tb/lin_txfault_sup_tb.sv
`timescale 1ns/1ps
module lin_txfault_sup_tb;

  localparam int TXD_T = 20;
  localparam int BUS_T = 50;
  localparam int CLMP  = 6;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          txd = 1'b1;
  logic          short_gnd = 1'b0, short_bat = 1'b0, ext_dom = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic          bus_rx, tx_en, term_en, slope_low, drive_boost, irq;
  logic [DW-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // wired bus: shorts win, otherwise dominant if our driver or another node pulls
  assign bus_rx = short_gnd ? 1'b0 : short_bat ? 1'b1 : ~((tx_en & ~txd) | ext_dom);

  lin_txfault_sup #(
    .TXD_TIMEOUT(TXD_T), .BUS_TIMEOUT(BUS_T), .CLAMP_FILT(CLMP),
    .SYNC_STAGES(2), .DATA_W(DW)
  ) u_dut (
    .clk(clk), .rst(rst), .txd_in(txd), .bus_rx(bus_rx),
    .tx_en(tx_en), .term_en(term_en), .slope_low(slope_low),
    .drive_boost(drive_boost), .irq(irq),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } exp_t;

  exp_t sb[$];

  function automatic int observe(int sel);
    case (sel)
      0: return int'(tx_en);
      1: return int'(term_en);
      2: return int'(irq);
      3: return int'(reg_rdata);
      4: return int'(slope_low);
      default: return int'(drive_boost);
    endcase
  endfunction

  // monitor: pop expected items and compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      int   act;
      it  = sb.pop_front();
      act = observe(it.sel);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_out(string req, int sel, int exp);
    sb.push_back('{req, sel, exp});
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_expect(string req, logic [1:0] a, int exp);
    reg_addr = a;
    @(posedge clk); #1;
    expect_out(req, 3, exp);
  endtask

  task automatic bus_pulse();
    ext_dom = 1'b1;
    cyc(3);
    ext_dom = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    expect_out("R1 tx_en", 0, 1);
    expect_out("R1 term_en", 1, 1);
    expect_out("R1 irq", 2, 0);
    expect_out("R1 slope", 4, 0);
    expect_out("R1 boost", 5, 0);
    rd_expect("R1 live", 2'd3, 0);
    rd_expect("R1 stat", 2'd2, 0);

    // R2 short dominant stretch keeps the driver on
    txd = 1'b0; cyc(10); txd = 1'b1; cyc(4);
    expect_out("R2 short stretch", 0, 1);

    // R2 long dominant stretch
    txd = 1'b0; cyc(TXD_T - 2);
    expect_out("R2 before limit", 0, 1);
    cyc(6);
    expect_out("R2 after limit", 0, 0);
    rd_expect("R2 live bit0", 2'd3, 1);
    // R9 masked change never latched
    rd_expect("R9 stat masked", 2'd2, 0);
    expect_out("R9 irq masked", 2, 0);

    // R11 enable register read back
    wr(2'd1, 8'h07);
    rd_expect("R11 ien readback", 2'd1, 7);

    // R3 recessive data alone does not re-enable
    txd = 1'b1; cyc(6);
    expect_out("R3 no bus edge", 0, 0);
    bus_pulse(); cyc(6);
    expect_out("R3 auto release", 0, 1);
    rd_expect("R3 live cleared", 2'd3, 0);
    // R8 enabled change latched
    rd_expect("R8 stat set", 2'd2, 1);
    expect_out("R8 irq set", 2, 1);
    wr(2'd2, 8'h01); cyc(1);
    rd_expect("R8 stat cleared", 2'd2, 0);
    expect_out("R8 irq cleared", 2, 0);

    // R3 bus edge while data still dominant does not release
    txd = 1'b0; cyc(TXD_T + 4);
    expect_out("R3 stuck again", 0, 0);
    bus_pulse(); cyc(4);
    expect_out("R3 edge with dominant data", 0, 0);
    txd = 1'b1; cyc(4);
    // R4 set alone is not enough
    wr(2'd0, 8'h01); cyc(3);
    expect_out("R4 set only", 0, 0);
    wr(2'd0, 8'h00); cyc(3);
    expect_out("R4 set then clear", 0, 1);
    wr(2'd2, 8'h07); cyc(2);

    // R5 recessive clamp
    short_bat = 1'b1; txd = 1'b0; cyc(12);
    expect_out("R5 clamp disables", 0, 0);
    rd_expect("R5 live bit2", 2'd3, 4);
    expect_out("R8 irq on clamp", 2, 1);
    txd = 1'b1; cyc(4);
    expect_out("R6 still off", 0, 0);
    short_bat = 1'b0; cyc(4);
    expect_out("R6 no edge yet", 0, 0);
    bus_pulse(); cyc(5);
    expect_out("R6 auto release", 0, 1);

    // R4 manual release of clamp
    short_bat = 1'b1; txd = 1'b0; cyc(12);
    txd = 1'b1;
    expect_out("R4 clamp off", 0, 0);
    wr(2'd0, 8'h01); cyc(2);
    wr(2'd0, 8'h00); cyc(3);
    expect_out("R4 clamp manual", 0, 1);
    short_bat = 1'b0; cyc(4);
    wr(2'd2, 8'h07); cyc(2);

    // R7 bus stuck dominant
    short_gnd = 1'b1; cyc(45);
    expect_out("R7 before limit", 1, 1);
    cyc(15);
    expect_out("R7 term off", 1, 0);
    expect_out("R7 driver unaffected", 0, 1);
    rd_expect("R7 live bit1", 2'd3, 2);
    short_gnd = 1'b0; cyc(5);
    expect_out("R7 term back", 1, 1);

    // R10 pass-through bits
    wr(2'd0, 8'h06); cyc(1);
    expect_out("R10 slope", 4, 1);
    expect_out("R10 boost", 5, 1);
    rd_expect("R10 ctrl readback", 2'd0, 6);

    cyc(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule